// File: doc/BRIEF.md
# Real-Time Clock Alarm Matcher

This block watches the running calendar time of a real-time clock and raises an alarm when that time agrees with a set of programmed alarm fields. Four BCD fields take part: seconds, minutes, hours and day-of-month. A 4-bit repeat code chooses which of them must agree. The comparison happens once per one-second tick. When it succeeds, a sticky alarm flag is set, and an active-low interrupt request follows the flag when interrupts are enabled.

Software clears the flag and the interrupt by reading the flags location of the clock register space. So that a read cannot lose an alarm that arrives while it is in progress, a match that happens while the flags address is held in the address latch is parked. It reaches the flag once the latch holds any other address. A separate enable governs the interrupt while the system runs from its backup supply. Time counting, register storage and supply switching live in neighbouring blocks, which supply the fields, enables and bus strobes as plain inputs.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset `alarm_flag` is 0 and `irq_n` is 1, and both stay there until a qualified match occurs.
- R2: With `rpt_code` = 4'b1111, every cycle with `sec_tick` = 1 is a match, whatever the time and alarm fields hold.
- R3: With `rpt_code` = 4'b1110, a tick matches when the seconds field equals the alarm seconds, and the other fields are ignored.
- R4: With `rpt_code` = 4'b1100, a tick matches when both minutes and seconds equal their alarm fields.
- R5: With `rpt_code` = 4'b1000, a tick matches when hours, minutes and seconds all equal their alarm fields. The date is ignored.
- R6: With `rpt_code` = 4'b0000, a tick matches only when date, hours, minutes and seconds all equal their alarm fields.
- R7: Any other `rpt_code` value behaves exactly like 4'b1111.
- R8: A match is evaluated only in a cycle with `sec_tick` = 1, and a match sets `alarm_flag` at the next clock edge.
- R9: `irq_n` is a registered output. One edge after the flag's new value is decided, it is 0 exactly when the flag is 1 and `flag_en` is 1 (outside backup mode). With `flag_en` = 0, only the flag is set.
- R10: While `in_bkup` = 1, `irq_n` goes low only when both `flag_en` and `bkup_en` are 1. The flag is set either way.
- R11: A cycle with `rd_stb` = 1 and `addr_lat` = FLAGS_ADDR (13'h1FF0) clears the flag, and `irq_n` returns to 1 at the next edge. A read at any other address leaves the flag unchanged.
- R12: A match while `addr_lat` = FLAGS_ADDR does not set the flag. It is held pending, survives reads of the flags address, and sets the flag at the first edge where `addr_lat` differs from FLAGS_ADDR.
- R13: With `rpt_code` = 4'b0000 and alarm date 8'h00, no tick ever matches, because the date field only takes the values 01 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse at each new second |
| cur_sec | input | FIELD_W | Current seconds, BCD |
| cur_min | input | FIELD_W | Current minutes, BCD |
| cur_hour | input | FIELD_W | Current hours, BCD, 24-hour |
| cur_date | input | FIELD_W | Current day of month, BCD |
| alm_sec | input | FIELD_W | Alarm seconds |
| alm_min | input | FIELD_W | Alarm minutes |
| alm_hour | input | FIELD_W | Alarm hours |
| alm_date | input | FIELD_W | Alarm day of month |
| rpt_code | input | 4 | Repeat code selecting compared fields |
| flag_en | input | 1 | Alarm interrupt enable |
| bkup_en | input | 1 | Interrupt enable during backup supply |
| in_bkup | input | 1 | System running from backup supply |
| rd_stb | input | 1 | Bus read strobe |
| addr_lat | input | ADDR_W | Currently latched bus address |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench walks each repeat code with time patterns that agree on every field except the one the code should still compare. A design whose field mask is off by one position would fire early there, or never. Unlisted codes are driven with no field agreeing, so a decoder that treated them as "compare all" would stay silent. The deferral case issues a match and then a flags read while the flags address is latched, and only then moves the address away. A design that set the flag at once, or dropped the pending match on the read, would show a cleared flag at the wrong moment or never raise it. The backup-mode and enable cases check that the flag still sets while the interrupt stays high.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;

  // field order inside the packed compare buses: 0 sec, 1 min, 2 hour, 3 date
  localparam int NFIELD = 4;

  typedef enum logic [2:0] {
    RM_SECOND,
    RM_MINUTE,
    RM_HOUR,
    RM_DAY,
    RM_MONTH
  } rpt_mode_e;

  function automatic rpt_mode_e decode_rpt(input logic [3:0] code);
    rpt_mode_e m;
    case (code)
      4'b1110: m = RM_MINUTE;
      4'b1100: m = RM_HOUR;
      4'b1000: m = RM_DAY;
      4'b0000: m = RM_MONTH;
      default: m = RM_SECOND;   // 1111 and all unlisted codes
    endcase
    return m;
  endfunction

  // bit i set: field i takes part in the comparison
  function automatic logic [NFIELD-1:0] mode_mask(input rpt_mode_e m);
    logic [NFIELD-1:0] k;
    case (m)
      RM_MINUTE: k = 4'b0001;
      RM_HOUR:   k = 4'b0011;
      RM_DAY:    k = 4'b0111;
      RM_MONTH:  k = 4'b1111;
      default:   k = 4'b0000;
    endcase
    return k;
  endfunction

  function automatic logic irq_level(input logic flag, input logic fen,
                                     input logic ben, input logic bk);
    return flag & fen & (~bk | ben);
  endfunction

endpackage

// File: rtl/alm_mode_decode.sv
module alm_mode_decode
  import rtc_alm_pkg::*;
(
  input  logic [3:0]        rpt_code,
  output logic [NFIELD-1:0] field_mask
);
  rpt_mode_e mode;
  always_comb begin
    mode       = decode_rpt(rpt_code);
    field_mask = mode_mask(mode);
  end
endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int FIELD_W = 8,
  parameter int NF      = 4,
  localparam int BUS_W  = FIELD_W * NF
) (
  input  logic [BUS_W-1:0] cur_bus,
  input  logic [BUS_W-1:0] alm_bus,
  input  logic [NF-1:0]    mask,
  output logic             all_eq
);
  logic [NF-1:0] fld_ok;
  genvar i;
  generate
    for (i = 0; i < NF; i++) begin : g_fld
      assign fld_ok[i] = ~mask[i] |
        (cur_bus[i*FIELD_W +: FIELD_W] == alm_bus[i*FIELD_W +: FIELD_W]);
    end
  endgenerate
  assign all_eq = &fld_ok;
endmodule

// File: rtl/alm_flag_ctl.sv
module alm_flag_ctl #(
  parameter int              ADDR_W     = 13,
  parameter logic [ADDR_W-1:0] FLAGS_ADDR = 13'h1FF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] addr_lat,
  output logic              flag_q,
  output logic              pend_q,
  output logic              flag_nxt
);
  logic at_flags;
  logic pend_nxt;

  assign at_flags = (addr_lat == FLAGS_ADDR);

  always_comb begin
    if (at_flags) begin
      // flags location latched: park new matches, allow clear-on-read
      pend_nxt = pend_q | hit;
      flag_nxt = flag_q & ~rd_stb;
    end else begin
      pend_nxt = 1'b0;
      flag_nxt = flag_q | hit | pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      pend_q <= pend_nxt;
    end
  end
endmodule

// File: rtl/alm_irq_gate.sv
module alm_irq_gate
  import rtc_alm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flag_nxt,
  input  logic flag_en,
  input  logic bkup_en,
  input  logic in_bkup,
  output logic irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~irq_level(flag_nxt, flag_en, bkup_en, in_bkup);
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alm_pkg::*;
#(
  parameter int                FIELD_W    = 8,
  parameter int                ADDR_W     = 13,
  parameter logic [ADDR_W-1:0] FLAGS_ADDR = 13'h1FF0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [FIELD_W-1:0] cur_date,
  input  logic [FIELD_W-1:0] alm_sec,
  input  logic [FIELD_W-1:0] alm_min,
  input  logic [FIELD_W-1:0] alm_hour,
  input  logic [FIELD_W-1:0] alm_date,
  input  logic [3:0]         rpt_code,
  input  logic               flag_en,
  input  logic               bkup_en,
  input  logic               in_bkup,
  input  logic               rd_stb,
  input  logic [ADDR_W-1:0]  addr_lat,
  output logic               alarm_flag,
  output logic               irq_n
);
  localparam int BUS_W = FIELD_W * NFIELD;

  logic [BUS_W-1:0]  cur_bus, alm_bus;
  logic [NFIELD-1:0] rpt_mask_w;
  logic              fields_eq_w;
  logic              hit_w;     // qualified match event, one per tick
  logic              pend_w;    // match parked while flags address latched
  logic              flag_nxt_w;

  assign cur_bus = {cur_date, cur_hour, cur_min, cur_sec};
  assign alm_bus = {alm_date, alm_hour, alm_min, alm_sec};

  alm_mode_decode u_dec (
    .rpt_code   (rpt_code),
    .field_mask (rpt_mask_w)
  );

  alm_field_cmp #(.FIELD_W(FIELD_W), .NF(NFIELD)) u_cmp (
    .cur_bus (cur_bus),
    .alm_bus (alm_bus),
    .mask    (rpt_mask_w),
    .all_eq  (fields_eq_w)
  );

  assign hit_w = sec_tick & fields_eq_w;

  alm_flag_ctl #(.ADDR_W(ADDR_W), .FLAGS_ADDR(FLAGS_ADDR)) u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit_w),
    .rd_stb   (rd_stb),
    .addr_lat (addr_lat),
    .flag_q   (alarm_flag),
    .pend_q   (pend_w),
    .flag_nxt (flag_nxt_w)
  );

  alm_irq_gate u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_nxt (flag_nxt_w),
    .flag_en  (flag_en),
    .bkup_en  (bkup_en),
    .in_bkup  (in_bkup),
    .irq_n    (irq_n)
  );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk #(
  parameter int                ADDR_W     = 13,
  parameter logic [ADDR_W-1:0] FLAGS_ADDR = 13'h1FF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              rd_stb,
  input logic [ADDR_W-1:0] addr_lat,
  input logic              flag_en,
  input logic              bkup_en,
  input logic              in_bkup,
  input logic              alarm_flag,
  input logic              irq_n,
  input logic              hit_w,
  input logic              pend_w
);
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> alarm_flag); // R9

  AST_IRQ_OFF_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flag_en) |-> irq_n); // R9

  AST_BACKUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_bkup && !bkup_en) |-> irq_n); // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && addr_lat == FLAGS_ADDR) |=> (!alarm_flag && irq_n)); // R11

  AST_NO_SET_WHILE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> ($past(addr_lat) != FLAGS_ADDR)); // R12

  AST_PEND_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    pend_w |-> ($past(addr_lat) == FLAGS_ADDR)); // R12

  AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(hit_w || pend_w)); // R8

  AST_PEND_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_w) |-> $past(sec_tick)); // R8
endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(
  .ADDR_W(ADDR_W), .FLAGS_ADDR(FLAGS_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_tick   (sec_tick),
  .rd_stb     (rd_stb),
  .addr_lat   (addr_lat),
  .flag_en    (flag_en),
  .bkup_en    (bkup_en),
  .in_bkup    (in_bkup),
  .alarm_flag (alarm_flag),
  .irq_n      (irq_n),
  .hit_w      (hit_w),
  .pend_w     (pend_w)
);

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
module rtc_alarm_match_test;
  localparam logic [12:0] FLG = 13'h1FF0;
  localparam logic [12:0] OTH = 13'h0100;

  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, rd_stb = 1'b0;
  logic [7:0] cs = 8'h00, cm = 8'h00, ch = 8'h00, cd = 8'h01;
  logic [7:0] as_ = 8'h00, am = 8'h00, ah = 8'h00, ad = 8'h01;
  logic [3:0] rpt = 4'b1111;
  logic fen = 1'b0, ben = 1'b0, bk = 1'b0;
  logic [12:0] addr = OTH;
  logic alarm_flag, irq_n;

  always #2.5 clk = ~clk;

  rtc_alarm_match uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_sec(cs), .cur_min(cm), .cur_hour(ch), .cur_date(cd),
    .alm_sec(as_), .alm_min(am), .alm_hour(ah), .alm_date(ad),
    .rpt_code(rpt), .flag_en(fen), .bkup_en(ben), .in_bkup(bk),
    .rd_stb(rd_stb), .addr_lat(addr),
    .alarm_flag(alarm_flag), .irq_n(irq_n)
  );

  int n_cmp = 0, n_bad = 0;
  bit    q_flag[$];
  bit    q_irq[$];
  string q_tag[$];
  bit m_flag = 0, m_pend = 0;
  bit done = 0;

  // expected match from the repeat-code table
  function automatic bit model_hit(input bit tick);
    bit s, mi, h, d;
    s = (cs == as_); mi = (cm == am); h = (ch == ah); d = (cd == ad);
    if (!tick) return 0;
    case (rpt)
      4'b1110: return s;
      4'b1100: return s && mi;
      4'b1000: return s && mi && h;
      4'b0000: return s && mi && h && d;
      default: return 1;
    endcase
  endfunction

  // driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic step(input bit tick, input bit rd, input logic [12:0] a,
                      input string tag);
    bit hit, exp_irq;
    sec_tick = tick; rd_stb = rd; addr = a;
    hit = model_hit(tick);
    if (a == FLG) begin
      m_pend = m_pend | hit;
      if (rd) m_flag = 0;
    end else begin
      m_flag = m_flag | hit | m_pend;
      m_pend = 0;
    end
    exp_irq = !(m_flag && fen && (!bk || ben));
    @(posedge clk); #1;
    sec_tick = 0; rd_stb = 0;
    q_flag.push_back(m_flag); q_irq.push_back(exp_irq); q_tag.push_back(tag);
  endtask

  task automatic clear_flag(input string tag);
    step(0, 1, FLG, tag);
    step(0, 0, OTH, tag);
  endtask

  task automatic set_cur(input logic [7:0] s, m, h, d);
    cs = s; cm = m; ch = h; cd = d;
  endtask

  task automatic set_alm(input logic [7:0] s, m, h, d);
    as_ = s; am = m; ah = h; ad = d;
  endtask

  // monitor: compares design outputs against queued expectations
  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      bit ef, ei; string t;
      ef = q_flag.pop_front(); ei = q_irq.pop_front(); t = q_tag.pop_front();
      n_cmp++;
      if (alarm_flag !== ef || irq_n !== ei) begin
        n_bad++;
        $display("FAIL %s: flag=%b irq_n=%b expected flag=%b irq_n=%b",
                 t, alarm_flag, irq_n, ef, ei);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    step(0, 0, OTH, "R1");
    step(0, 0, OTH, "R1");

    // R2: code 1111 fires with no field agreeing
    set_cur(8'h11, 8'h22, 8'h03, 8'h04); set_alm(8'h59, 8'h58, 8'h23, 8'h31);
    rpt = 4'b1111;
    step(0, 0, OTH, "R8");   // no tick, no flag
    step(1, 0, OTH, "R2");
    clear_flag("R11");

    // R3: seconds only
    rpt = 4'b1110;
    set_alm(8'h30, 8'h00, 8'h00, 8'h01); set_cur(8'h31, 8'h10, 8'h05, 8'h09);
    step(1, 0, OTH, "R3");
    set_cur(8'h30, 8'h10, 8'h05, 8'h09);
    step(0, 0, OTH, "R8");   // matching fields but no tick
    step(1, 0, OTH, "R3");
    clear_flag("R11");

    // R4: minutes and seconds
    rpt = 4'b1100;
    set_alm(8'h15, 8'h45, 8'h12, 8'h07); set_cur(8'h14, 8'h45, 8'h01, 8'h02);
    step(1, 0, OTH, "R4");
    set_cur(8'h15, 8'h45, 8'h01, 8'h02);
    step(1, 0, OTH, "R4");
    clear_flag("R11");

    // R5: hours, minutes, seconds; date ignored
    rpt = 4'b1000;
    set_cur(8'h15, 8'h45, 8'h11, 8'h02);
    step(1, 0, OTH, "R5");
    set_cur(8'h15, 8'h45, 8'h12, 8'h02);
    step(1, 0, OTH, "R5");
    clear_flag("R11");

    // R6: all four fields
    rpt = 4'b0000;
    step(1, 0, OTH, "R6");
    set_cur(8'h15, 8'h45, 8'h12, 8'h07);
    step(1, 0, OTH, "R6");
    clear_flag("R11");

    // R13: date zero with code 0000 never fires
    set_alm(8'h15, 8'h45, 8'h12, 8'h00); set_cur(8'h15, 8'h45, 8'h12, 8'h01);
    step(1, 0, OTH, "R13");
    set_cur(8'h15, 8'h45, 8'h12, 8'h31);
    step(1, 0, OTH, "R13");

    // R7: unlisted codes act as once per second
    set_alm(8'h59, 8'h58, 8'h23, 8'h31); set_cur(8'h01, 8'h02, 8'h03, 8'h04);
    rpt = 4'b1010;
    step(1, 0, OTH, "R7");
    clear_flag("R11");
    rpt = 4'b0110;
    step(1, 0, OTH, "R7");
    clear_flag("R11");

    // R9: interrupt follows flag when enabled
    rpt = 4'b1111; fen = 1;
    step(1, 0, OTH, "R9");
    step(0, 1, OTH, "R11");  // read elsewhere keeps flag and interrupt
    fen = 0;
    step(0, 0, OTH, "R9");   // enable dropped: irq releases, flag stays
    clear_flag("R11");

    // R10: backup mode needs both enables
    bk = 1; fen = 1; ben = 0;
    step(1, 0, OTH, "R10");
    ben = 1;
    step(0, 0, OTH, "R10");
    fen = 0;
    step(0, 0, OTH, "R10");
    clear_flag("R11");
    bk = 0; ben = 0; fen = 1;

    // R12: match while flags address latched is deferred
    step(0, 0, FLG, "R12");
    step(1, 0, FLG, "R12");
    step(0, 1, FLG, "R12");  // read does not lose the parked match
    step(0, 0, FLG, "R12");
    step(0, 0, OTH, "R12");  // flag appears once address moves
    clear_flag("R11");
    fen = 0;

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule